// File: doc/BRIEF.md
# Byte-Wide NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide NOR flash. It turns one command into the full bus traffic the flash needs. The command is a byte program, an erase of any set of sectors, or a whole-chip erase. For each command the block issues the unlock writes and the command writes, one strobed write cycle at a time. It then reads the flash repeatedly and watches data bit 7. While the embedded operation runs, that bit reads back inverted; when the operation ends, it reads back the true value.

Each poll read is charged against a per-operation limit counted in clock cycles. A command ends in one of three ways: success, timeout, or rejection when the command is malformed. A one-cycle done pulse marks the end, and the result flags stay valid until the next command is accepted. Write pulse width, write-high time and poll read length are clock-count parameters, so the timing can be fitted to the flash speed grade and the system clock.

Top module: `fseq_ctrl`

## Requirements
- R1: Operation code 0 (program) issues exactly four writes, in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the command data to the command address.
- R2: Operation code 1 (sector erase) issues AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. It then writes 30h once for every set bit of the sector mask, in ascending sector order. The sector index forms the address bits above bit 15, and the lower 16 bits are zero. All of these writes come before any poll read.
- R3: Operation code 2 (chip erase) issues the same five-write preamble as R2, then a single write of 10h to 5555h.
- R4: Every write cycle works as follows. Chip select goes low at least one clock before write enable falls, and stays low through the clock in which write enable rises. Write enable is low for exactly WE_LOW_CLKS clocks. Address and data stay unchanged while write enable is low and on the edge where it rises.
- R5: Polling uses read cycles in which output enable is low, write enable is high and the data driver is off. The poll succeeds on the first read whose bit 7 equals the expected value: bit 7 of the command data for a program, 1 for either erase.
- R6: Each read lasts RD_CLKS+1 clocks. Suppose read k fails and k·(RD_CLKS+1) is at least the operation's limit (PROG_TMO, SERASE_TMO or CERASE_TMO). Then the command ends with timeout and no further reads. A read that matches always ends in success, even when the limit is reached on that read.
- R7: Every command ends with `done` high for exactly one clock. At most one of `ok` and `timeout` is high, and both hold their values until the next command is accepted.
- R8: Operation code 3, or a sector erase with an all-zero mask, is rejected. No bus cycle is issued, and `done` pulses with `ok` and `timeout` both low.
- R9: A command presented while `busy` is high has no effect. No extra bus writes occur, and the running command's result is unchanged.
- R10: During reset, and after it, chip select, write enable and output enable are high, the data driver is off, and `busy`, `done`, `ok` and `timeout` are low. This holds even if reset arrives in the middle of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| cmd_addr | input | ADDR_W | Program target; also the address polled |
| cmd_data | input | 8 | Byte to program |
| cmd_sectors | input | NSECT | One bit per sector to erase |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| ok | output | 1 | Last command succeeded |
| timeout | output | 1 | Last command exceeded its time limit |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_wdata | output | 8 | Write data toward the flash |
| flash_wdata_oe | output | 1 | Enable for the write-data driver |
| flash_d7 | input | 1 | Data bit 7 read from the flash |

## Verification
Two decisions can fall on the same poll read: the end of the operation, seen as true data on bit 7, and the time limit running out. The bench sets up this case by letting the flash model return inverted data for exactly one read fewer than the limit permits. The last permitted read therefore carries the true bit. The result must be success, not timeout, after exactly that many reads. One more inverted read must then give timeout with the same read count. The bench checks both boundaries for all three operation types.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_RSVD   = 2'd3
  } fseq_op_e;

  // One entry of an unlock/command preamble.
  typedef struct packed {
    logic        use_tgt;  // take address and data from the command instead
    logic [15:0] addr;
    logic [7:0]  data;
  } fseq_step_t;

  localparam logic [15:0] ADR_KEY1  = 16'h5555;
  localparam logic [15:0] ADR_KEY2  = 16'h2AAA;
  localparam logic [7:0]  BYTE_K1   = 8'hAA;
  localparam logic [7:0]  BYTE_K2   = 8'h55;
  localparam logic [7:0]  BYTE_PROG = 8'hA0;
  localparam logic [7:0]  BYTE_ERS  = 8'h80;
  localparam logic [7:0]  BYTE_CHIP = 8'h10;
  localparam logic [7:0]  BYTE_SECT = 8'h30;

  // Index of the final preamble write for an operation.
  function automatic logic [2:0] fseq_last_step(fseq_op_e op);
    case (op)
      OP_PROG:   fseq_last_step = 3'd3;
      OP_SERASE: fseq_last_step = 3'd4;
      default:   fseq_last_step = 3'd5;
    endcase
  endfunction

  function automatic fseq_step_t fseq_step(fseq_op_e op, logic [2:0] idx);
    fseq_step_t s;
    s = '{use_tgt: 1'b0, addr: ADR_KEY1, data: BYTE_K1};
    case (idx)
      3'd0: s = '{use_tgt: 1'b0, addr: ADR_KEY1, data: BYTE_K1};
      3'd1: s = '{use_tgt: 1'b0, addr: ADR_KEY2, data: BYTE_K2};
      3'd2: s = '{use_tgt: 1'b0, addr: ADR_KEY1,
                  data: (op == OP_PROG) ? BYTE_PROG : BYTE_ERS};
      3'd3: s = (op == OP_PROG) ? '{use_tgt: 1'b1, addr: 16'h0, data: 8'h0}
                                : '{use_tgt: 1'b0, addr: ADR_KEY1, data: BYTE_K1};
      3'd4: s = '{use_tgt: 1'b0, addr: ADR_KEY2, data: BYTE_K2};
      default: s = '{use_tgt: 1'b0, addr: ADR_KEY1, data: BYTE_CHIP};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fseq_wr_strobe.sv
module fseq_wr_strobe #(
  parameter int unsigned LOW_CLKS  = 5,
  parameter int unsigned HIGH_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cs_n,
  output logic we_n,
  output logic drive,
  output logic fin
);

  localparam int unsigned MAXC = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {W_IDLE, W_SET, W_LOW, W_HIGH} wph_e;

  wph_e          ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          cs_n_q, we_n_q, drv_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    fin    = 1'b0;
    case (ph_q)
      W_IDLE: if (start) ph_d = W_SET;
      W_SET: begin
        ph_d   = W_LOW;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      W_LOW: begin
        cnt_en = 1'b1;
        if (cnt_q == CW'(LOW_CLKS - 1)) begin
          ph_d  = W_HIGH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        cnt_en = 1'b1;
        if (cnt_q == CW'(HIGH_CLKS - 1)) begin
          ph_d = W_IDLE;
          fin  = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= W_IDLE;
      cnt_q  <= '0;
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      drv_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      if (cnt_en) cnt_q <= cnt_d;
      cs_n_q <= (ph_d == W_IDLE);
      we_n_q <= (ph_d != W_LOW);
      drv_q  <= (ph_d != W_IDLE);
    end
  end

  assign cs_n  = cs_n_q;
  assign we_n  = we_n_q;
  assign drive = drv_q;

  p_we_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);
  p_cs_before_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!cs_n));
  p_cs_hold_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !cs_n && drive);

endmodule

// File: rtl/fseq_poll.sv
module fseq_poll #(
  parameter int unsigned RD_CLKS = 10,
  parameter int unsigned TMO_W   = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             expect_d7,
  input  logic [TMO_W-1:0] limit,
  input  logic             d7_in,
  output logic             cs_n,
  output logic             oe_n,
  output logic             fin,
  output logic             pass,
  output logic             tmo
);

  localparam int unsigned RCW = $clog2(RD_CLKS + 1);

  typedef enum logic [1:0] {P_IDLE, P_RD, P_REC} pph_e;

  pph_e             ph_q, ph_d;
  logic [RCW-1:0]   cnt_q, cnt_d;
  logic [TMO_W-1:0] el_q, el_d;
  logic             smp_q, smp_en;
  logic             cs_n_q, oe_n_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    el_d   = el_q;
    smp_en = 1'b0;
    fin    = 1'b0;
    pass   = 1'b0;
    tmo    = 1'b0;
    case (ph_q)
      P_IDLE: if (start) begin
        ph_d  = P_RD;
        cnt_d = '0;
        el_d  = '0;
      end
      P_RD: begin
        el_d = el_q + TMO_W'(1);
        if (cnt_q == RCW'(RD_CLKS - 1)) begin
          ph_d   = P_REC;
          smp_en = 1'b1;
        end else begin
          cnt_d = cnt_q + RCW'(1);
        end
      end
      default: begin
        el_d = el_q + TMO_W'(1);
        if (smp_q == expect_d7) begin
          ph_d = P_IDLE;
          fin  = 1'b1;
          pass = 1'b1;
        end else if (el_q >= limit - TMO_W'(1)) begin
          ph_d = P_IDLE;
          fin  = 1'b1;
          tmo  = 1'b1;
        end else begin
          ph_d  = P_RD;
          cnt_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= P_IDLE;
      cnt_q  <= '0;
      el_q   <= '0;
      smp_q  <= 1'b0;
      cs_n_q <= 1'b1;
      oe_n_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      el_q   <= el_d;
      if (smp_en) smp_q <= d7_in;
      cs_n_q <= (ph_d == P_IDLE);
      oe_n_q <= (ph_d != P_RD);
    end
  end

  assign cs_n = cs_n_q;
  assign oe_n = oe_n_q;

  p_oe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cs_n);
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (pass ^ tmo));

endmodule

// File: rtl/fseq_sect_pick.sv
module fseq_sect_pick #(
  parameter int unsigned NSECT = 8,
  localparam int unsigned SECT_W = $clog2(NSECT)
) (
  input  logic [NSECT-1:0]  mask,
  output logic [SECT_W-1:0] idx
);

  // Lowest set bit wins: scan downward so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (mask[i]) idx = SECT_W'(i);
    end
  end

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned NSECT        = 8,
  parameter int unsigned WE_LOW_CLKS  = 5,
  parameter int unsigned WE_HIGH_CLKS = 2,
  parameter int unsigned RD_CLKS      = 10,
  parameter int unsigned TMO_W        = 33,
  parameter logic [TMO_W-1:0] PROG_TMO   = 33'd30_000,
  parameter logic [TMO_W-1:0] SERASE_TMO = 33'd1_500_000_000,
  parameter logic [TMO_W-1:0] CERASE_TMO = 33'd6_400_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [NSECT-1:0]  cmd_sectors,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              timeout,
  output logic              flash_cs_n,
  output logic              flash_we_n,
  output logic              flash_oe_n,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_wdata,
  output logic              flash_wdata_oe,
  input  logic              flash_d7
);

  localparam int unsigned SECT_W = $clog2(NSECT);
  localparam int unsigned OFF_W  = ADDR_W - SECT_W;

  typedef enum logic [2:0] {
    T_IDLE, T_ISSUE, T_WAIT, T_SECT, T_SWAIT, T_PGO, T_POLL, T_DONE
  } tst_e;

  tst_e              st_q, st_d;
  fseq_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [NSECT-1:0]  mask_q, mask_d;
  logic [2:0]        step_q, step_d;
  logic              ld_cmd, mask_en, step_en;
  logic [ADDR_W-1:0] bus_addr_q, bus_addr_d;
  logic [7:0]        bus_data_q, bus_data_d;
  logic              bus_en;
  logic              res_ok_q, res_tmo_q, res_en, res_ok_d, res_tmo_d;

  logic              wr_start, wr_cs_n, wr_we_n, wr_drv, wr_fin;
  logic              pl_start, pl_cs_n, pl_oe_n, pl_fin, pl_pass, pl_tmo;
  logic              exp_d7;
  logic [TMO_W-1:0]  limit;
  logic [SECT_W-1:0] pick;
  fseq_step_t        stp;
  fseq_op_e          op_in;

  assign op_in = fseq_op_e'(cmd_op);
  assign stp   = fseq_step(op_q, step_q);

  fseq_sect_pick #(.NSECT(NSECT)) u_pick (
    .mask (mask_q),
    .idx  (pick)
  );

  fseq_wr_strobe #(.LOW_CLKS(WE_LOW_CLKS), .HIGH_CLKS(WE_HIGH_CLKS)) u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_start),
    .cs_n  (wr_cs_n),
    .we_n  (wr_we_n),
    .drive (wr_drv),
    .fin   (wr_fin)
  );

  always_comb begin
    case (op_q)
      OP_PROG:   limit = PROG_TMO;
      OP_SERASE: limit = SERASE_TMO;
      default:   limit = CERASE_TMO;
    endcase
  end
  assign exp_d7 = (op_q == OP_PROG) ? data_q[7] : 1'b1;

  fseq_poll #(.RD_CLKS(RD_CLKS), .TMO_W(TMO_W)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pl_start),
    .expect_d7 (exp_d7),
    .limit     (limit),
    .d7_in     (flash_d7),
    .cs_n      (pl_cs_n),
    .oe_n      (pl_oe_n),
    .fin       (pl_fin),
    .pass      (pl_pass),
    .tmo       (pl_tmo)
  );

  always_comb begin
    st_d       = st_q;
    ld_cmd     = 1'b0;
    mask_d     = mask_q;
    mask_en    = 1'b0;
    step_d     = step_q;
    step_en    = 1'b0;
    bus_addr_d = bus_addr_q;
    bus_data_d = bus_data_q;
    bus_en     = 1'b0;
    wr_start   = 1'b0;
    pl_start   = 1'b0;
    res_en     = 1'b0;
    res_ok_d   = 1'b0;
    res_tmo_d  = 1'b0;
    case (st_q)
      T_IDLE: if (cmd_valid) begin
        ld_cmd  = 1'b1;
        res_en  = 1'b1;
        step_d  = '0;
        step_en = 1'b1;
        if (op_in == OP_RSVD || (op_in == OP_SERASE && cmd_sectors == '0))
          st_d = T_DONE;
        else
          st_d = T_ISSUE;
      end
      T_ISSUE: begin
        bus_en     = 1'b1;
        bus_addr_d = stp.use_tgt ? addr_q : ADDR_W'(stp.addr);
        bus_data_d = stp.use_tgt ? data_q : stp.data;
        wr_start   = 1'b1;
        st_d       = T_WAIT;
      end
      T_WAIT: if (wr_fin) begin
        if (step_q == fseq_last_step(op_q)) begin
          st_d = (op_q == OP_SERASE) ? T_SECT : T_PGO;
        end else begin
          step_d  = step_q + 3'd1;
          step_en = 1'b1;
          st_d    = T_ISSUE;
        end
      end
      T_SECT: begin
        bus_en     = 1'b1;
        bus_addr_d = {pick, {OFF_W{1'b0}}};
        bus_data_d = BYTE_SECT;
        wr_start   = 1'b1;
        mask_d     = mask_q & ~(NSECT'(1) << pick);
        mask_en    = 1'b1;
        st_d       = T_SWAIT;
      end
      T_SWAIT: if (wr_fin) st_d = (mask_q == '0) ? T_PGO : T_SECT;
      T_PGO: begin
        bus_en     = 1'b1;
        bus_addr_d = addr_q;
        pl_start   = 1'b1;
        st_d       = T_POLL;
      end
      T_POLL: if (pl_fin) begin
        res_en    = 1'b1;
        res_ok_d  = pl_pass;
        res_tmo_d = pl_tmo;
        st_d      = T_DONE;
      end
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= T_IDLE;
      op_q       <= OP_PROG;
      addr_q     <= '0;
      data_q     <= '0;
      mask_q     <= '0;
      step_q     <= '0;
      bus_addr_q <= '0;
      bus_data_q <= '0;
      res_ok_q   <= 1'b0;
      res_tmo_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ld_cmd) begin
        op_q   <= op_in;
        addr_q <= cmd_addr;
        data_q <= cmd_data;
        mask_q <= cmd_sectors;
      end else if (mask_en) begin
        mask_q <= mask_d;
      end
      if (step_en) step_q <= step_d;
      if (bus_en) begin
        bus_addr_q <= bus_addr_d;
        bus_data_q <= bus_data_d;
      end
      if (res_en) begin
        res_ok_q  <= res_ok_d;
        res_tmo_q <= res_tmo_d;
      end
    end
  end

  assign busy           = (st_q != T_IDLE);
  assign done           = (st_q == T_DONE);
  assign ok             = res_ok_q;
  assign timeout        = res_tmo_q;
  assign flash_cs_n     = wr_cs_n & pl_cs_n;
  assign flash_we_n     = wr_we_n;
  assign flash_oe_n     = pl_oe_n;
  assign flash_wdata_oe = wr_drv;
  assign flash_addr     = bus_addr_q;
  assign flash_wdata    = bus_data_q;

  p_no_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> flash_we_n && !flash_wdata_oe);
  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |=> $stable(flash_addr) && $stable(flash_wdata));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_result_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && timeout));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> flash_cs_n && flash_we_n && flash_oe_n);

endmodule

// File: tb/tb_fseq_ctrl.sv
module tb_fseq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WL   = 3;
  localparam int WH   = 2;
  localparam int RDC  = 2;
  localparam int RDP  = RDC + 1;
  localparam int LIM_P = 20;
  localparam int LIM_S = 30;
  localparam int LIM_C = 40;

  logic        clk, rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [18:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic [7:0]  cmd_sectors;
  logic        busy, done, ok, timeout;
  logic        flash_cs_n, flash_we_n, flash_oe_n, flash_wdata_oe, flash_d7;
  logic [18:0] flash_addr;
  logic [7:0]  flash_wdata;

  fseq_ctrl #(
    .WE_LOW_CLKS(WL), .WE_HIGH_CLKS(WH), .RD_CLKS(RDC),
    .PROG_TMO(33'(LIM_P)), .SERASE_TMO(33'(LIM_S)), .CERASE_TMO(33'(LIM_C))
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sectors(cmd_sectors),
    .busy(busy), .done(done), .ok(ok), .timeout(timeout),
    .flash_cs_n(flash_cs_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n),
    .flash_addr(flash_addr), .flash_wdata(flash_wdata),
    .flash_wdata_oe(flash_wdata_oe), .flash_d7(flash_d7)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit good, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [18:0] log_a [0:31];
  logic [7:0]  log_d [0:31];
  int          n_wr = 0;
  int          n_rd = 0;
  int          busy_left = 0;
  logic        true7 = 1'b0;
  int          strobe_err = 0;
  int          low_cnt = 0;
  logic [18:0] held_a;
  logic [7:0]  held_d;

  assign flash_d7 = (busy_left > 0) ? ~true7 : true7;

  always @(posedge flash_we_n) begin
    if (rst_n === 1'b1) begin
      if (flash_cs_n !== 1'b0) strobe_err++;
      if (n_wr < 32) begin
        log_a[n_wr] = flash_addr;
        log_d[n_wr] = flash_wdata;
      end
      n_wr++;
    end
  end

  always @(posedge flash_oe_n) begin
    if (rst_n === 1'b1) begin
      n_rd++;
      if (busy_left > 0) busy_left--;
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (flash_we_n === 1'b0) begin
        if (flash_cs_n !== 1'b0) strobe_err++;
        if (low_cnt == 0) begin
          held_a = flash_addr;
          held_d = flash_wdata;
        end else if (flash_addr !== held_a || flash_wdata !== held_d) begin
          strobe_err++;
        end
        low_cnt++;
      end else if (low_cnt != 0) begin
        if (low_cnt != WL) strobe_err++;
        low_cnt = 0;
      end
      if (flash_oe_n === 1'b0 &&
          (flash_we_n !== 1'b1 || flash_wdata_oe !== 1'b0 || flash_cs_n !== 1'b0))
        strobe_err++;
    end
  end

  // ---------------- expected sequence ----------------
  logic [18:0] ex_a [0:31];
  logic [7:0]  ex_d [0:31];
  int          n_ex;

  task automatic push(input logic [18:0] a, input logic [7:0] d);
    ex_a[n_ex] = a;
    ex_d[n_ex] = d;
    n_ex++;
  endtask

  task automatic build_expect(input logic [1:0] op, input logic [18:0] a,
                              input logic [7:0] d, input logic [7:0] m);
    n_ex = 0;
    if (op == 2'd0) begin
      push(19'h05555, 8'hAA); push(19'h02AAA, 8'h55);
      push(19'h05555, 8'hA0); push(a, d);
    end else if ((op == 2'd1 && m != 8'h00) || op == 2'd2) begin
      push(19'h05555, 8'hAA); push(19'h02AAA, 8'h55); push(19'h05555, 8'h80);
      push(19'h05555, 8'hAA); push(19'h02AAA, 8'h55);
      if (op == 2'd2) push(19'h05555, 8'h10);
      else
        for (int i = 0; i < 8; i++)
          if (m[i]) push({3'(i), 16'h0000}, 8'h30);
    end
  endtask

  function automatic string req_of(input logic [1:0] op, input logic [7:0] m);
    if (op == 2'd0) return "R1";
    if (op == 2'd2) return "R3";
    if (op == 2'd1 && m != 0) return "R2";
    return "R8";
  endfunction

  // ---------------- command driver ----------------
  logic got_ok, got_tmo;
  bit   hung;

  task automatic run_cmd(input logic [1:0] op, input logic [18:0] a,
                         input logic [7:0] d, input logic [7:0] m,
                         input int nbusy, input int inject_at);
    int cyc;
    n_wr = 0; n_rd = 0; strobe_err = 0;
    busy_left = nbusy;
    true7 = (op == 2'd0) ? d[7] : 1'b1;
    hung = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sectors = m;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (done !== 1'b1) begin
      if (inject_at > 0 && cyc == inject_at) begin
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = 19'h0; cmd_sectors = 8'hFF;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin
        hung = 1'b1;
        break;
      end
    end
    cmd_valid = 1'b0;
    got_ok  = ok;
    got_tmo = timeout;
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [1:0]  op;
    logic [18:0] addr;
    logic [7:0]  data;
    logic [7:0]  mask;
    logic [7:0]  nbusy;
    logic [1:0]  res;   // 0 success, 1 timeout, 2 rejected
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 19'h12345, 8'h3C, 8'h00, 8'd2,  2'd0},
    '{2'd0, 19'h7FFFF, 8'hA5, 8'h00, 8'd0,  2'd0},
    '{2'd0, 19'h00010, 8'h80, 8'h00, 8'd6,  2'd0},
    '{2'd0, 19'h00011, 8'h01, 8'h00, 8'd7,  2'd1},
    '{2'd1, 19'h10000, 8'h00, 8'h01, 8'd3,  2'd0},
    '{2'd1, 19'h50000, 8'h00, 8'hA5, 8'd9,  2'd0},
    '{2'd1, 19'h70000, 8'h00, 8'h80, 8'd10, 2'd1},
    '{2'd2, 19'h00000, 8'h00, 8'h00, 8'd13, 2'd0},
    '{2'd2, 19'h00000, 8'h00, 8'h00, 8'd14, 2'd1},
    '{2'd1, 19'h00000, 8'h00, 8'h00, 8'd0,  2'd2},
    '{2'd1, 19'h00000, 8'h00, 8'hFF, 8'd1,  2'd0},
    '{2'd3, 19'h00123, 8'h77, 8'h0F, 8'd0,  2'd2}
  };

  function automatic int max_reads(input logic [1:0] op);
    int lim;
    lim = (op == 2'd0) ? LIM_P : (op == 2'd1) ? LIM_S : LIM_C;
    return (lim + RDP - 1) / RDP;
  endfunction

  task automatic check_seq(input string req);
    check(n_wr == n_ex, req, "write count", n_wr, n_ex);
    for (int i = 0; i < n_ex && i < n_wr; i++)
      check(log_a[i] == ex_a[i] && log_d[i] == ex_d[i], req, "write entry",
            {log_a[i], log_d[i]}, {ex_a[i], ex_d[i]});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0; cmd_sectors = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state during reset
    check(flash_cs_n && flash_we_n && flash_oe_n && !flash_wdata_oe, "R10",
          "strobes in reset", {flash_cs_n, flash_we_n, flash_oe_n, flash_wdata_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !ok && !timeout, "R10", "status after reset",
          {busy, done, ok, timeout}, 4'b0000);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int   exp_rd;
      t = VECS[v];
      build_expect(t.op, t.addr, t.data, t.mask);
      run_cmd(t.op, t.addr, t.data, t.mask, int'(t.nbusy), 0);
      check(!hung, "R7", "done seen", hung, 0);
      check_seq(req_of(t.op, t.mask));
      check(strobe_err == 0, "R4", "strobe timing errors", strobe_err, 0);
      if (t.res == 2'd2) exp_rd = 0;
      else if (int'(t.nbusy) < max_reads(t.op)) exp_rd = int'(t.nbusy) + 1;
      else exp_rd = max_reads(t.op);
      check(n_rd == exp_rd, (t.res == 2'd1) ? "R6" : "R5", "poll read count", n_rd, exp_rd);
      check({got_ok, got_tmo} == {t.res == 2'd0, t.res == 2'd1},
            (t.res == 2'd1) ? "R6" : (t.res == 2'd2) ? "R8" : "R5", "result",
            {got_ok, got_tmo}, {t.res == 2'd0, t.res == 2'd1});
      @(negedge clk);
      check(!done, "R7", "done one cycle", done, 0);
      repeat (3) @(negedge clk);
      check(ok == got_ok && timeout == got_tmo, "R7", "result held",
            {ok, timeout}, {got_ok, got_tmo});
    end

    // R9: a second command while busy has no effect
    build_expect(2'd0, 19'h0ABCD, 8'h5A, 8'h00);
    run_cmd(2'd0, 19'h0ABCD, 8'h5A, 8'h00, 3, 10);
    check(got_ok && !got_tmo, "R9", "result with intruder", {got_ok, got_tmo}, 2'b10);
    repeat (20) @(negedge clk);
    check(!busy, "R9", "stays idle after", busy, 0);
    check_seq("R9");

    // R10: reset in the middle of a chip erase poll
    busy_left = 100; true7 = 1'b1; n_wr = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (60) @(negedge clk);
    check(busy, "R10", "busy before reset", busy, 1);
    rst_n = 1'b0;
    #1;
    check(flash_cs_n && flash_we_n && flash_oe_n && !busy && !done, "R10",
          "mid-command reset", {flash_cs_n, flash_we_n, flash_oe_n, busy, done}, 5'b11100);
    @(negedge clk);
    rst_n = 1'b1;
    busy_left = 0;
    repeat (5) @(negedge clk);
    check(!busy && !ok && !timeout && flash_cs_n, "R10", "idle after reset",
          {busy, ok, timeout, flash_cs_n}, 4'b0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule